// File: doc/BRIEF.md
# Residue-to-Binary Converter with Sign Output

This block turns a number held as three residues, for the moduli 2^n−1, 2^n and 2^n+1, back into an ordinary binary integer. It uses the Chinese Remainder Theorem. Each residue is first scaled by the inverse of its weight with respect to its own modulus. For all three moduli that inverse is a halving or a negation, so it costs a rotation, a complement or a one-bit shift. The scaled residue is then multiplied by its weight. Every weight is a sum or difference of two powers of two, so no multiplier and no table is needed. The three projections are added and the sum is folded into the range [0, M), where M = 2^n·(2^{2n}−1).

The block also reads the range as signed. Values in the upper half of the range stand for negative numbers. A sign flag and a two's-complement result come out together with the unsigned value. Two register stages hold the data: the first holds the projection sum, the second holds the reduced value and the sign. A valid flag travels alongside the data. With the default n = 4 the moduli are 15, 16 and 17, and M = 4080.

Top module: `rns_rev_conv`

## Requirements
- R1: While reset is asserted and after it is released, with no input accepted yet, out_valid, out_value, out_neg and out_signed are all zero.
- R2: out_valid equals in_valid delayed by exactly two clock edges, and a new triple can be accepted on every cycle.
- R3: For in-range residues of an integer X in [0, M) (res_lo = X mod 2^n−1, res_mid = X mod 2^n, res_hi = X mod 2^n+1, where res_hi may reach 2^n), out_value equals X.
- R4: Whenever out_valid is high, out_value is below M.
- R5: out_neg is 1 exactly when out_value ≥ M/2 (2040 for n = 4).
- R6: out_signed equals out_value when out_neg is 0, and equals out_value − M taken as a 3n-bit two's-complement number when out_neg is 1.
- R7: A res_lo of all ones (2^n−1) is treated as the residue 0, which is congruent to it.
- R8: When in_valid is low, the triple on the residue inputs has no effect: out_value, out_neg and out_signed keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The residue triple is present this cycle |
| res_lo | input | N | Residue for modulus 2^N−1 |
| res_mid | input | N | Residue for modulus 2^N |
| res_hi | input | N+1 | Residue for modulus 2^N+1 (0 to 2^N) |
| out_valid | output | 1 | Result registers hold a new conversion |
| out_value | output | 3N | Reconstructed unsigned value in [0, M) |
| out_neg | output | 1 | Value lies in the upper half of the range |
| out_signed | output | 3N | Two's-complement reading of the value |

## Verification
The bench works through every integer of the range. This exposes a wrong inverse or a wrong weight: such a design returns the right value only for triples where the faulty projection happens to be zero. It also exposes a missing second subtraction, which would leave values at or above M on the output.

The bench aims at the sign boundary: M/2−1, M/2, M/2+1 and M−1. An off-by-one comparison flips the flag and the signed value at exactly one of these points. It feeds the all-ones low residue, which a plain rotation would turn into an extra M. It streams triples back to back, which catches a stage that drops or repeats data. Finally it changes the inputs while in_valid is low, which a pipeline that loads on every cycle would pass through to the output.

// File: rtl/rns_pkg.sv
package rns_pkg;

    // How many times the dynamic range is taken off the projection sum.
    typedef enum logic [1:0] {
        SUB_NONE  = 2'd0,
        SUB_ONCE  = 2'd1,
        SUB_TWICE = 2'd2
    } sub_sel_e;

endpackage

// File: rtl/rns_projection.sv
module rns_projection #(
    parameter int N = 4
) (
    input  logic [N-1:0]   r_lo,
    input  logic [N-1:0]   r_mid,
    input  logic [N:0]     r_hi,
    output logic [3*N+1:0] proj_sum
);
    localparam int W = 3*N + 2;
    localparam logic [N+1:0] HI_MOD_EXT = (N+2)'((1 << N) + 1);

    logic [N-1:0] t_lo;
    logic [N-1:0] t_mid;
    logic [N+1:0] hi_plus;
    logic [N:0]   t_hi;
    logic [W-1:0] e_lo, e_mid, e_hi;
    logic [W-1:0] p_lo, p_mid, p_hi;

    // Inverse of the low weight is 1/2 mod (2^N-1): a right rotation.
    always_comb t_lo = (&r_lo) ? '0 : {r_lo[0], r_lo[N-1:1]};

    // Inverse of the middle weight is -1 mod 2^N.
    always_comb t_mid = (~r_mid) + N'(1);

    // Inverse of the high weight is 1/2 mod (2^N+1): halve, adding the modulus when odd.
    always_comb hi_plus = {1'b0, r_hi} + HI_MOD_EXT;
    always_comb t_hi    = r_hi[0] ? hi_plus[N+1:1] : {1'b0, r_hi[N:1]};

    always_comb begin
        e_lo  = W'(t_lo);
        e_mid = W'(t_mid);
        e_hi  = W'(t_hi);
        p_lo  = (e_lo  << (2*N)) + (e_lo << N);   // weight 2^N(2^N+1)
        p_mid = (e_mid << (2*N)) - e_mid;         // weight 2^2N-1
        p_hi  = (e_hi  << (2*N)) - (e_hi << N);   // weight 2^N(2^N-1)
        proj_sum = p_lo + p_mid + p_hi;
    end
endmodule

// File: rtl/rns_mod_reduce.sv
module rns_mod_reduce
    import rns_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [3*N+1:0] sum_in,
    output logic [3*N-1:0] value,
    output logic           neg,
    output logic [3*N-1:0] value_signed
);
    localparam int W = 3*N + 2;
    localparam logic [W-1:0] ONE    = W'(1);
    localparam logic [W-1:0] MOD_M  = (ONE << (3*N)) - (ONE << N);
    localparam logic [W-1:0] TWO_M  = MOD_M << 1;
    localparam logic [W-1:0] HALF_M = MOD_M >> 1;
    localparam logic [3*N-1:0] MOD_T = MOD_M[3*N-1:0];

    sub_sel_e     sel;
    logic [W-1:0] less_one, less_two, reduced;

    always_comb begin
        less_one = sum_in - MOD_M;
        less_two = sum_in - TWO_M;
        if (sum_in >= TWO_M)      sel = SUB_TWICE;
        else if (sum_in >= MOD_M) sel = SUB_ONCE;
        else                      sel = SUB_NONE;
    end

    always_comb begin
        unique case (sel)
            SUB_TWICE: reduced = less_two;
            SUB_ONCE:  reduced = less_one;
            default:   reduced = sum_in;
        endcase
    end

    always_comb begin
        value        = reduced[3*N-1:0];
        neg          = (reduced >= HALF_M);
        value_signed = neg ? (value - MOD_T) : value;
    end
endmodule

// File: rtl/rns_rev_conv.sv
module rns_rev_conv #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   res_lo,
    input  logic [N-1:0]   res_mid,
    input  logic [N:0]     res_hi,
    output logic           out_valid,
    output logic [3*N-1:0] out_value,
    output logic           out_neg,
    output logic [3*N-1:0] out_signed
);
    localparam int W = 3*N + 2;

    logic [W-1:0]   proj_sum;
    logic           s1_valid;
    logic [W-1:0]   s1_sum;
    logic [3*N-1:0] red_value, red_signed;
    logic           red_neg;

    rns_projection #(.N(N)) u_proj (
        .r_lo     (res_lo),
        .r_mid    (res_mid),
        .r_hi     (res_hi),
        .proj_sum (proj_sum)
    );

    // Stage 1: projection sum.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sum   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_sum <= proj_sum;
        end
    end

    rns_mod_reduce #(.N(N)) u_red (
        .sum_in       (s1_sum),
        .value        (red_value),
        .neg          (red_neg),
        .value_signed (red_signed)
    );

    // Stage 2: reduced value and sign.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_value  <= '0;
            out_neg    <= 1'b0;
            out_signed <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_value  <= red_value;
                out_neg    <= red_neg;
                out_signed <= red_signed;
            end
        end
    end
endmodule

// File: rtl/rns_rev_conv_chk.sv
module rns_rev_conv_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N-1:0]   res_lo,
    input logic [N-1:0]   res_mid,
    input logic [N:0]     res_hi,
    input logic           out_valid,
    input logic [3*N-1:0] out_value,
    input logic           out_neg,
    input logic [3*N-1:0] out_signed
);
    localparam int V = 3*N;
    localparam logic [V-1:0] ONE    = V'(1);
    localparam logic [V-1:0] MOD_T  = (ONE << (3*N)) - (ONE << N);
    localparam logic [V-1:0] HALF_M = (((ONE << (3*N-1)) - (ONE << (N-1))));
    localparam logic [V-1:0] LO_MOD = (ONE << N) - ONE;
    localparam logic [V-1:0] HI_MOD = (ONE << N) + ONE;

    logic           iv_d1, iv_d2;
    logic [N-1:0]   lo_d1, lo_d2, mid_d1, mid_d2;
    logic [N:0]     hi_d1, hi_d2;
    logic [V-1:0]   lo_w, hi_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iv_d1 <= 1'b0; iv_d2 <= 1'b0;
            lo_d1 <= '0; lo_d2 <= '0; mid_d1 <= '0; mid_d2 <= '0;
            hi_d1 <= '0; hi_d2 <= '0;
        end else begin
            iv_d1 <= in_valid; iv_d2 <= iv_d1;
            lo_d1 <= res_lo;  lo_d2 <= lo_d1;
            mid_d1 <= res_mid; mid_d2 <= mid_d1;
            hi_d1 <= res_hi;  hi_d2 <= hi_d1;
        end
    end

    always_comb begin
        lo_w = V'(lo_d2);
        hi_w = V'(hi_d2);
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == iv_d2); // R2
    AST_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_value < MOD_T); // R4
    AST_MID_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_value[N-1:0] == mid_d2); // R3
    AST_HI_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_value % HI_MOD) == hi_w); // R3
    AST_LO_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_value % LO_MOD) == (lo_w % LO_MOD)); // R7
    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_neg == (out_value >= HALF_M)); // R5
    AST_SIGNED_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_neg) |-> out_signed == out_value); // R6
    AST_SIGNED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_neg) |-> V'(out_signed + MOD_T) == out_value); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !iv_d1 |=> ($stable(out_value) && $stable(out_neg) && $stable(out_signed))); // R8
endmodule

bind rns_rev_conv rns_rev_conv_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .res_lo     (res_lo),
    .res_mid    (res_mid),
    .res_hi     (res_hi),
    .out_valid  (out_valid),
    .out_value  (out_value),
    .out_neg    (out_neg),
    .out_signed (out_signed)
);

// File: tb/rns_rev_conv_tb.sv
`timescale 1ns/1ps
module rns_rev_conv_tb;
    localparam int N      = 4;
    localparam int V      = 3*N;
    localparam int M      = (1 << (3*N)) - (1 << N);
    localparam int HALF   = M / 2;

    // {value, expected sign, expected 12-bit two's-complement value}
    localparam logic [24:0] VEC [12] = '{
        {12'd0,    1'b0, 12'd0},
        {12'd1,    1'b0, 12'd1},
        {12'd16,   1'b0, 12'd16},
        {12'd255,  1'b0, 12'd255},
        {12'd1020, 1'b0, 12'd1020},
        {12'd2039, 1'b0, 12'd2039},
        {12'd2040, 1'b1, 12'd2056},
        {12'd2041, 1'b1, 12'd2057},
        {12'd3000, 1'b1, 12'd3016},
        {12'd3060, 1'b1, 12'd3076},
        {12'd4078, 1'b1, 12'd4094},
        {12'd4079, 1'b1, 12'd4095}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N-1:0]   res_lo = '0;
    logic [N-1:0]   res_mid = '0;
    logic [N:0]     res_hi = '0;
    logic           out_valid;
    logic [V-1:0]   out_value;
    logic           out_neg;
    logic [V-1:0]   out_signed;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rns_rev_conv #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .res_lo(res_lo), .res_mid(res_mid), .res_hi(res_hi),
        .out_valid(out_valid), .out_value(out_value),
        .out_neg(out_neg), .out_signed(out_signed)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input int x, input logic v);
        in_valid = v;
        res_lo   = N'(x % ((1 << N) - 1));
        res_mid  = N'(x % (1 << N));
        res_hi   = (N+1)'(x % ((1 << N) + 1));
    endtask

    function automatic int exp_signed(input int x);
        return (x >= HALF) ? ((x - M) & ((1 << V) - 1)) : x;
    endfunction

    // Single conversion; results are sampled two falling edges later.
    task automatic convert(input int x);
        @(negedge clk); drive(x, 1'b1);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(out_valid), 0);
        chk("R1 value in reset", int'(out_value), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 valid after reset", int'(out_valid), 0);
        chk("R1 value after reset", int'(out_value), 0);
        chk("R1 neg after reset", int'(out_neg), 0);
        chk("R1 signed after reset", int'(out_signed), 0);

        // Vector table, corners of the range and of the sign boundary.
        for (int i = 0; i < 12; i++) begin
            convert(int'(VEC[i][24:13]));
            chk("R2 valid", int'(out_valid), 1);
            chk("R3 value", int'(out_value), int'(VEC[i][24:13]));
            chk("R5 sign", int'(out_neg), int'(VEC[i][12]));
            chk("R6 signed", int'(out_signed), int'(VEC[i][11:0]));
        end

        // Full sweep of the range.
        for (int x = 0; x < M; x++) begin
            convert(x);
            chk("R3 sweep value", int'(out_value), x);
            chk("R4 below M", int'(out_value < V'(M)), 1);
            chk("R5 sweep sign", int'(out_neg), int'(x >= HALF));
            chk("R6 sweep signed", int'(out_signed), exp_signed(x));
        end

        // R7: all-ones low residue stands for zero (X = 30).
        @(negedge clk);
        in_valid = 1'b1; res_lo = '1; res_mid = N'(30 % 16); res_hi = (N+1)'(30 % 17);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk("R7 all-ones low residue", int'(out_value), 30);

        // R2: back-to-back stream, one result per cycle.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R2 stream valid", int'(out_valid), 1);
                chk("R2 stream value", int'(out_value), 400 * (i - 2) + 7);
            end
            if (i < 8) drive(400 * i + 7, 1'b1);
            else       in_valid = 1'b0;
        end
        @(negedge clk);
        chk("R2 stream drained", int'(out_valid), 0);

        // R8: inputs change while in_valid is low.
        convert(2500);
        @(negedge clk); drive(100, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 value held", int'(out_value), 2500);
        chk("R8 sign held", int'(out_neg), 1);
        chk("R8 signed held", int'(out_signed), exp_signed(2500));
        chk("R8 valid low", int'(out_valid), 0);

        // R1: reset in mid operation clears the outputs.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset value", int'(out_value), 0);
        chk("R1 mid-run reset neg", int'(out_neg), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule